// File: doc/BRIEF.md
# Lockable Flash Timing Tick Divider

This block holds one 8-bit control register and from it derives the slow timing enable that flash program and erase sequencers count against. The register sets a division ratio for the bus clock. A divide-by-8 prescale stage can be switched in ahead of a 6-bit programmable stage. The output is a tick, one bus clock wide, that repeats at the selected ratio. Software writes the register once after reset. The load-control bit in that write decides whether later writes are accepted or the register freezes until the next reset.

A read returns the stored prescale and divider fields. Bit 7 of a read does not return the load-control value that was written. It reports whether any write has been accepted since reset. A fault flag shows when the resulting tick rate, worked out from the bus clock frequency given as a parameter, falls outside the 150 kHz to 200 kHz band that flash timing needs. A second flag shows that the divider is not yet set up.

Top module: `flash_tick_div`

## Requirements
- R1: After reset, rd_data reads 0x00, tick is low and unconfigured is high.
- R2: Bit 7 of rd_data reads 1 once any write has been accepted since reset, and 0 before that. Bit 6 returns the stored prescale enable and bits 5:0 return the stored divider value D.
- R3: An accepted write with bit 7 = 0 locks the register. Every later write is ignored until reset: rd_data stays unchanged and the tick phase does not restart.
- R4: An accepted write with bit 7 = 1 leaves the register writable, so the next write is accepted. That next write's bit 7 again decides whether the register locks.
- R5: With bit 6 = 0, tick goes high for one cycle every D+1 bus clock cycles. With D = 1 the ratio is 2, which is the minimum.
- R6: With bit 6 = 1, the ratio is 8*(D+1). With D = 63 the ratio is 512, which is the maximum.
- R7: While no write has been accepted since reset, or while D = 0, unconfigured is high and tick stays low.
- R8: An accepted write restarts both counters. The first tick then appears in the N-th cycle after the write edge, where N is the new ratio.
- R9: out_of_range is high exactly when BUS_HZ divided by the current ratio is below MIN_HZ or above MAX_HZ.
- R10: rd_data follows the register state combinationally. A write takes effect at the clock edge where wr_en is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write value: bit 7 load control, bit 6 prescale enable, bits 5:0 D |
| rd_data | output | 8 | Read value: bit 7 written-since-reset, bit 6 prescale, bits 5:0 D |
| tick | output | 1 | One-cycle timing enable |
| unconfigured | output | 1 | Divider inactive (no write accepted yet, or D = 0) |
| out_of_range | output | 1 | Resulting tick rate lies outside MIN_HZ..MAX_HZ |

## Verification
The bench builds the block with BUS_HZ = 8 MHz and the default 150 kHz to 200 kHz band. At that clock the in-band ratios run from 40 to 53, so both edges of the band can be reached: ratio 40 sits exactly at 200 kHz, ratio 53 is just above 150 kHz, and ratio 54 is just below it. Some of these ratios are reached with the prescaler and some without. The minimum ratio of 2 and the maximum of 512 are also run to completion. Two separate reset episodes cover the lock path and the stay-writable path.

// File: rtl/flash_tick_pkg.sv
package flash_tick_pkg;
  // True when bus_hz / ratio lies outside [min_hz, max_hz]; written without division.
  function automatic logic rate_outside(input longint bus_hz, input longint min_hz,
                                        input longint max_hz, input longint ratio);
    return (bus_hz < ratio * min_hz) || (bus_hz > ratio * max_hz);
  endfunction
endpackage

// File: rtl/ftd_cfg_reg.sv
module ftd_cfg_reg #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W+1:0] wr_data,
  output logic [DIV_W+1:0] rd_data,
  output logic             pre_en,
  output logic [DIV_W-1:0] div_val,
  output logic             written,
  output logic             locked,
  output logic             accept
);
  logic             pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_q, wr_d;
  logic             lock_q, lock_d;

  assign accept = wr_en && !lock_q;

  always_comb begin
    pre_d  = pre_q;
    div_d  = div_q;
    wr_d   = wr_q;
    lock_d = lock_q;
    if (accept) begin
      pre_d  = wr_data[DIV_W];
      div_d  = wr_data[DIV_W-1:0];
      wr_d   = 1'b1;
      lock_d = !wr_data[DIV_W+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= 1'b0;
      div_q  <= '0;
      wr_q   <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      div_q  <= div_d;
      wr_q   <= wr_d;
      lock_q <= lock_d;
    end
  end

  assign rd_data = {wr_q, pre_q, div_q};
  assign pre_en  = pre_q;
  assign div_val = div_q;
  assign written = wr_q;
  assign locked  = lock_q;
endmodule

// File: rtl/ftd_prescale.sv
module ftd_prescale #(
  parameter int PRE_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable,
  input  logic bypass,
  output logic pre_tick
);
  generate
    if (PRE_LOG2 == 0) begin : g_none
      assign pre_tick = enable;
    end else begin : g_cnt
      logic [PRE_LOG2-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (restart || !enable || bypass) cnt_d = '0;
        else                              cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign pre_tick = enable && (bypass || (&cnt_q));
    end
  endgenerate
endmodule

// File: rtl/ftd_count.sv
module ftd_count #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             enable,
  input  logic             step,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == div_val);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !enable) cnt_d = '0;
    else if (step)          cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = enable && step && wrap;
endmodule

// File: rtl/flash_tick_div.sv
module flash_tick_div #(
  parameter longint BUS_HZ   = 8000000,
  parameter longint MIN_HZ   = 150000,
  parameter longint MAX_HZ   = 200000,
  parameter int     DIV_W    = 6,
  parameter int     PRE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W+1:0] wr_data,
  output logic [DIV_W+1:0] rd_data,
  output logic             tick,
  output logic             unconfigured,
  output logic             out_of_range
);
  localparam int RATIO_W = DIV_W + PRE_LOG2 + 1;

  logic               pre_en, written, lock_q, accept, active, pre_tick;
  logic [DIV_W-1:0]   div_val;
  logic [RATIO_W-1:0] ratio;

  ftd_cfg_reg #(.DIV_W(DIV_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pre_en(pre_en), .div_val(div_val),
    .written(written), .locked(lock_q), .accept(accept)
  );

  assign active = written && (div_val != '0);

  ftd_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(accept), .enable(active),
    .bypass(!pre_en), .pre_tick(pre_tick)
  );

  ftd_count #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(accept), .enable(active),
    .step(pre_tick), .div_val(div_val), .tick(tick)
  );

  always_comb begin
    ratio = RATIO_W'({1'b0, div_val}) + 1'b1;
    if (pre_en) ratio = ratio << PRE_LOG2;
  end

  assign unconfigured = !active;
  assign out_of_range = flash_tick_pkg::rate_outside(BUS_HZ, MIN_HZ, MAX_HZ,
                          longint'({{(64-RATIO_W){1'b0}}, ratio}));
endmodule

// File: rtl/ftd_checker.sv
module ftd_checker #(
  parameter int RD_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [RD_W-1:0] rd_data,
  input logic            tick,
  input logic            unconfigured,
  input logic            locked,
  input logic            accept
);
  // R7: no tick while the divider is inactive
  a_r7_idle_when_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
    unconfigured |-> !tick);

  // R2: a register never read as written cannot be active
  a_r2_unwritten_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[RD_W-1] |-> unconfigured);

  // R3: writes to a locked register change nothing
  a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en) |=> $stable(rd_data));

  // R5: the tick is a single cycle wide (minimum ratio 2)
  a_r5_single_cycle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R8: an accepted write restarts the counters, so no tick follows at once
  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tick);

  // R10: the written flag only rises at a sampled write strobe
  a_r10_written_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[RD_W-1]) |-> $past(wr_en));
endmodule

bind flash_tick_div ftd_checker #(.RD_W(DIV_W + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data), .tick(tick),
  .unconfigured(unconfigured), .locked(lock_q), .accept(accept)
);

// File: tb/flash_tick_div_tb_top.sv
module flash_tick_div_tb_top;
  localparam longint BUS_HZ = 8000000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick, unconfigured, out_of_range;

  always #2 clk = ~clk;

  flash_tick_div #(.BUS_HZ(BUS_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .unconfigured(unconfigured),
    .out_of_range(out_of_range)
  );

  typedef struct { int ratio; bit act; } exp_t;
  exp_t q[$];
  exp_t cur = '{ratio: 1, act: 1'b0};
  int   k = 0;
  int   errors = 0, checks = 0;
  bit   done = 1'b0;

  // independent model of the register
  bit       m_written, m_locked;
  bit [6:0] m_reg;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_ratio();
    return (int'(m_reg[5:0]) + 1) * (m_reg[6] ? 8 : 1);
  endfunction

  function automatic bit m_oor();
    longint r = longint'(m_ratio());
    return (BUS_HZ < r * 150000) || (BUS_HZ > r * 200000);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_written = 0; m_locked = 0; m_reg = '0;
    q.push_back('{ratio: 1, act: 1'b0});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(rd_data == 8'h00, "R1", "rd_data after reset", rd_data, 0);
    chk(unconfigured == 1'b1, "R1", "unconfigured after reset", unconfigured, 1);
    chk(tick == 1'b0, "R1", "tick after reset", tick, 0);
  endtask

  // driver: write, update model, push expectation for accepted writes
  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk);
    if (!m_locked) begin
      m_reg = v[6:0]; m_written = 1; m_locked = !v[7];
      q.push_back('{ratio: m_ratio(), act: m_reg[5:0] != 0});
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(rd_data == {m_written, m_reg}, "R2", "rd_data after write", rd_data, {m_written, m_reg});
    chk(unconfigured == (m_reg[5:0] == 0), "R7", "unconfigured", unconfigured, m_reg[5:0] == 0);
    chk(out_of_range == m_oor(), "R9", "out_of_range", out_of_range, m_oor());
  endtask

  // monitor: compare tick against the expected phase every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0) begin cur = q.pop_front(); k = 1; end
      else k++;
      chk(tick == (cur.act && (k % cur.ratio == 0)), cur.ratio > 8 ? "R6/R8" : "R5/R8",
          "tick", tick, cur.act && (k % cur.ratio == 0));
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    repeat (10) @(negedge clk);
    chk(tick == 1'b0, "R7", "idle before first write", tick, 0);
    chk(out_of_range == 1'b1, "R9", "reset ratio 1", out_of_range, 1);
    do_write(8'h81);             // R5 minimum ratio 2
    repeat (20) @(negedge clk);
    do_write(8'hA7);             // R5 ratio 40, band edge 200 kHz
    repeat (100) @(negedge clk);
    do_write(8'hC4);             // R6 prescaled ratio 40
    repeat (200) @(negedge clk);
    do_write(8'hB4);             // R9 ratio 53 in band
    repeat (120) @(negedge clk);
    do_write(8'hB5);             // R9 ratio 54 below band
    repeat (120) @(negedge clk);
    do_write(8'h80);             // R7 D=0 idle
    repeat (30) @(negedge clk);
    do_write(8'hFF);             // R6 maximum ratio 512
    repeat (1100) @(negedge clk);
    do_write(8'h45);             // R4 accepted, R3 now locked, ratio 48
    chk(rd_data[7] == 1'b1, "R2", "bit7 shows written not lock", rd_data[7], 1);
    repeat (100) @(negedge clk);
    do_write(8'h81);             // R3 ignored, no restart
    chk(rd_data == 8'hC5, "R3", "locked rd_data", rd_data, 8'hC5);
    repeat (200) @(negedge clk);
    do_reset();                  // R1 reset clears the lock
    do_write(8'h03);             // R3 first write locks, ratio 4
    repeat (20) @(negedge clk);
    do_write(8'h8A);             // R3 ignored
    chk(rd_data == 8'h83, "R3", "locked after first write", rd_data, 8'h83);
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule